// File: doc/BRIEF.md
# Halfword Load Data Formatter

This block sits between a 32-bit little-endian data memory port and the register write-back path of a small processor core. It takes one load at a time: unsigned halfword, signed byte or signed halfword. For each load it issues a single-cycle memory request at the word-aligned address. It waits for the read response, picks the addressed halfword or byte out of the returned word, and delivers a 32-bit register value with zero-extension, sign-extension or rotation applied.

Odd addresses for the halfword loads are handled under one of two architecture rules, chosen per load by a mode input. The legacy rule rotates an unsigned halfword so that its low byte moves to the top of the result. A signed halfword at an odd address yields only its upper byte, sign-extended. The newer rule ignores address bit 0 for halfword loads, so the aligned halfword is always returned. An operation code of zero is not a load. It raises an error pulse and makes no memory access.

Top module: `hwld_fmt`

## Requirements
- R1: While reset is held, `mem_req_o`, `res_valid_o` and `err_illegal_o` are low and `req_ready_o` is high.
- R2: A load accepted on a clock edge (`req_valid_i` and `req_ready_o` high, op not 00) drives `mem_req_o` high for exactly the next cycle. During that cycle `mem_addr_o` equals the request address with bits 1:0 cleared.
- R3: The edge that samples `mem_rvalid_i` high while a load waits sets `res_valid_o` high for exactly one cycle, carrying the formatted value.
- R4: Op 01 (unsigned halfword) in legacy mode (`arch_new_i`=0): the halfword is selected by address bit 1 (0 = bits 15:0, 1 = bits 31:16) and zero-extended. The result is then rotated right by 8 bits when address bit 0 is 1, so the halfword's low byte lands in bits 31:24.
- R5: Op 01 in newer mode (`arch_new_i`=1): the selected halfword is zero-extended with no rotation, whatever address bit 0 is.
- R6: Op 11 (signed halfword) in legacy mode at an odd address: the result is bits 15:8 of the selected halfword, sign-extended from bit 7.
- R7: Op 11 at an even address in either mode, or at any address in newer mode: the full selected halfword is sign-extended from bit 15.
- R8: Op 10 (signed byte): the byte at lane address[1:0] (lane n = bits 8n+7:8n) is sign-extended to 32 bits in both modes.
- R9: Op 00 accepted while idle raises `err_illegal_o` for the next cycle. It issues no memory request and produces no `res_valid_o`.
- R10: A request presented while `req_ready_o` is low is ignored. It triggers no error, no extra memory request and no change to the load in flight.
- R11: The mode input is sampled when the load is accepted. Changing it afterwards does not alter that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_op_i | input | 2 | Load kind: 01 unsigned half, 10 signed byte, 11 signed half, 00 illegal |
| req_addr_i | input | AW (32) | Byte address of the load |
| arch_new_i | input | 1 | 0 legacy odd-address rule, 1 newer force-align rule |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | AW (32) | Word-aligned read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W (32) | Read word |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 32 | Formatted register value |
| err_illegal_o | output | 1 | One-cycle illegal operation flag |

## Verification
The bench targets odd addresses at both halfword positions under each mode. A swapped rule shows up there as a missing or misplaced rotation, or as sign-extension from bit 15 where bit 7 of the upper byte was expected. Words with the relevant sign bits set and clear expose extension that fills from the wrong bit, and all four byte lanes catch a wrong byte select. The bench also flips the mode input and presents an illegal request while a load is in flight. A design that reads the live pin, or accepts while busy, then returns the wrong rule or a spurious error.

// File: rtl/hwld_pkg.sv
package hwld_pkg;

   typedef enum logic [1:0] {
      LD_ILLEGAL = 2'b00,
      LD_UHALF   = 2'b01,
      LD_SBYTE   = 2'b10,
      LD_SHALF   = 2'b11
   } ld_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } ld_state_e;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned HALF_W = 16;
   localparam int unsigned BYTE_W = 8;

   // Arch source selection for the top
   localparam int unsigned ARCH_FROM_PIN   = 0;
   localparam int unsigned ARCH_FIX_LEGACY = 1;
   localparam int unsigned ARCH_FIX_NEW    = 2;

endpackage

// File: rtl/hwld_ctrl.sv
module hwld_ctrl
   import hwld_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid_i,
   input  ld_op_e        req_op_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic          arch_new_i,
   output logic          ready_o,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   input  logic          mem_rvalid_i,
   output logic          load_o,
   output ld_op_e        op_o,
   output logic [OFF_W-1:0] lsb_o,
   output logic          arch_new_o,
   output logic          err_o
);

   ld_state_e          state_q;
   ld_op_e             op_q;
   logic [AW-1:OFF_W]  wadr_q;
   logic [OFF_W-1:0]   lsb_q;
   logic               arch_q;
   logic               err_q;
   logic               accept;

   assign accept = (state_q == ST_IDLE) && req_valid_i;

   // R10: requests outside idle are not looked at
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= LD_UHALF;
         wadr_q  <= '0;
         lsb_q   <= '0;
         arch_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (req_op_i == LD_ILLEGAL) begin
                     err_q <= 1'b1;                 // R9
                  end else begin
                     op_q    <= req_op_i;
                     wadr_q  <= req_addr_i[AW-1:OFF_W];
                     lsb_q   <= req_addr_i[OFF_W-1:0];
                     arch_q  <= arch_new_i;         // R11
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;          // R2
            ST_WAIT: begin
               if (mem_rvalid_i) state_q <= ST_IDLE; // R3
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ready_o    = (state_q == ST_IDLE);
   assign mem_req_o  = (state_q == ST_ISSUE);
   assign mem_addr_o = {wadr_q, {OFF_W{1'b0}}};
   assign load_o     = (state_q == ST_WAIT) && mem_rvalid_i;
   assign op_o       = op_q;
   assign lsb_o      = lsb_q;
   assign arch_new_o = arch_q;
   assign err_o      = err_q;

endmodule

// File: rtl/hwld_lane_sel.sv
module hwld_lane_sel
   import hwld_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]           word_i,
   input  logic [$clog2(DATA_W/8)-1:0] lsb_i,
   input  logic                        arch_new_i,
   output logic [HALF_W-1:0]           half_o,
   output logic [BYTE_W-1:0]           byte_o,
   output logic                        odd_legacy_o
);

   localparam int unsigned LANES  = DATA_W / BYTE_W;
   localparam int unsigned HALVES = DATA_W / HALF_W;
   localparam int unsigned OFF_W  = $clog2(LANES);

   logic [HALF_W-1:0] half_arr [HALVES];
   logic [BYTE_W-1:0] byte_arr [LANES];

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign half_arr[h] = word_i[h*HALF_W +: HALF_W];
   end

   for (genvar b = 0; b < LANES; b++) begin : g_byte
      assign byte_arr[b] = word_i[b*BYTE_W +: BYTE_W];
   end

   // Halfword index ignores bit 0, which is the force-align of the newer rule
   assign half_o = half_arr[lsb_i[OFF_W-1:1]];
   assign byte_o = byte_arr[lsb_i];          // R8
   assign odd_legacy_o = lsb_i[0] && !arch_new_i;

endmodule

// File: rtl/hwld_extend.sv
module hwld_extend
   import hwld_pkg::*;
(
   input  ld_op_e            op_i,
   input  logic              odd_legacy_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [REG_W-1:0]  value_o
);

   logic [REG_W-1:0] zhalf;
   logic [REG_W-1:0] zrot;
   logic [REG_W-1:0] shalf;
   logic [REG_W-1:0] shigh;
   logic [REG_W-1:0] sbyte;

   assign zhalf = {{(REG_W-HALF_W){1'b0}}, half_i};
   assign zrot  = {zhalf[BYTE_W-1:0], zhalf[REG_W-1:BYTE_W]};
   assign shalf = {{(REG_W-HALF_W){half_i[HALF_W-1]}}, half_i};
   assign shigh = {{(REG_W-BYTE_W){half_i[HALF_W-1]}}, half_i[HALF_W-1:BYTE_W]};
   assign sbyte = {{(REG_W-BYTE_W){byte_i[BYTE_W-1]}}, byte_i};

   always_comb begin
      unique case (op_i)
         LD_UHALF: value_o = odd_legacy_i ? zrot  : zhalf;   // R4 R5
         LD_SHALF: value_o = odd_legacy_i ? shigh : shalf;   // R6 R7
         LD_SBYTE: value_o = sbyte;                          // R8
         default:  value_o = '0;
      endcase
   end

endmodule

// File: rtl/hwld_fmt.sv
module hwld_fmt
   import hwld_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ARCH_MODE = ARCH_FROM_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [1:0]        req_op_i,
   input  logic [AW-1:0]     req_addr_i,
   input  logic              arch_new_i,
   output logic              mem_req_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              res_valid_o,
   output logic [31:0]       res_data_o,
   output logic              err_illegal_o
);

   localparam int unsigned LANES = DATA_W / BYTE_W;
   localparam int unsigned OFF_W = $clog2(LANES);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("hwld_fmt: DATA_W must be a power of two of at least 32");
   end
   if (AW <= OFF_W) begin : g_bad_aw
      $error("hwld_fmt: AW too small for the word offset");
   end
   if (ARCH_MODE > ARCH_FIX_NEW) begin : g_bad_mode
      $error("hwld_fmt: ARCH_MODE out of range");
   end

   logic arch_eff;
   if (ARCH_MODE == ARCH_FIX_LEGACY) begin : g_arch_legacy
      logic unused_arch;
      assign unused_arch = arch_new_i;
      assign arch_eff = 1'b0;
   end else if (ARCH_MODE == ARCH_FIX_NEW) begin : g_arch_new
      logic unused_arch;
      assign unused_arch = arch_new_i;
      assign arch_eff = 1'b1;
   end else begin : g_arch_pin
      assign arch_eff = arch_new_i;
   end

   ld_op_e           op_in;
   ld_op_e           op_q;
   logic [OFF_W-1:0] lsb_q;
   logic             arch_q;
   logic             load;
   logic [HALF_W-1:0] half_sel;
   logic [BYTE_W-1:0] byte_sel;
   logic             odd_legacy;
   logic [REG_W-1:0] fmt_val;
   logic             res_valid_q;
   logic [REG_W-1:0] res_data_q;

   assign op_in = ld_op_e'(req_op_i);

   hwld_ctrl #(.AW(AW), .OFF_W(OFF_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_op_i     (op_in),
      .req_addr_i   (req_addr_i),
      .arch_new_i   (arch_eff),
      .ready_o      (req_ready_o),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rvalid_i (mem_rvalid_i),
      .load_o       (load),
      .op_o         (op_q),
      .lsb_o        (lsb_q),
      .arch_new_o   (arch_q),
      .err_o        (err_illegal_o)
   );

   hwld_lane_sel #(.DATA_W(DATA_W)) u_lane (
      .word_i       (mem_rdata_i),
      .lsb_i        (lsb_q),
      .arch_new_i   (arch_q),
      .half_o       (half_sel),
      .byte_o       (byte_sel),
      .odd_legacy_o (odd_legacy)
   );

   hwld_extend u_ext (
      .op_i         (op_q),
      .odd_legacy_i (odd_legacy),
      .half_i       (half_sel),
      .byte_i       (byte_sel),
      .value_o      (fmt_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_q <= 1'b0;
         res_data_q  <= '0;
      end else begin
         res_valid_q <= load;                 // R3
         if (load) res_data_q <= fmt_val;
      end
   end

   assign res_valid_o = res_valid_q;
   assign res_data_o  = res_data_q;

endmodule

// File: rtl/hwld_fmt_chk.sv
module hwld_fmt_chk #(
   parameter int unsigned AW     = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid_i,
   input logic              req_ready_o,
   input logic [1:0]        req_op_i,
   input logic              mem_req_o,
   input logic [AW-1:0]     mem_addr_o,
   input logic              mem_rvalid_i,
   input logic              res_valid_o,
   input logic              err_illegal_o
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!mem_req_o && !res_valid_o && !err_illegal_o && req_ready_o)); // R1

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o); // R2

   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R2

   AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_o) |-> $past(req_valid_i && req_ready_o && req_op_i != 2'b00)); // R2

   AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o); // R3

   AST_RES_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $past(mem_rvalid_i && !req_ready_o)); // R3

   AST_ERR_FROM_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      err_illegal_o |-> $past(req_valid_i && req_ready_o && req_op_i == 2'b00)); // R9

   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err_illegal_o |-> (!mem_req_o && !res_valid_o)); // R9

   AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready_o |=> !err_illegal_o); // R10

endmodule

bind hwld_fmt hwld_fmt_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid_i   (req_valid_i),
   .req_ready_o   (req_ready_o),
   .req_op_i      (req_op_i),
   .mem_req_o     (mem_req_o),
   .mem_addr_o    (mem_addr_o),
   .mem_rvalid_i  (mem_rvalid_i),
   .res_valid_o   (res_valid_o),
   .err_illegal_o (err_illegal_o)
);

// File: tb/hwld_fmt_tb_top.sv
`timescale 1ns/1ps
module hwld_fmt_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid_i = 1'b0;
   logic        req_ready_o;
   logic [1:0]  req_op_i = 2'b01;
   logic [31:0] req_addr_i = '0;
   logic        arch_new_i = 1'b0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic        mem_rvalid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        res_valid_o;
   logic [31:0] res_data_o;
   logic        err_illegal_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hwld_fmt dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
      .req_op_i(req_op_i), .req_addr_i(req_addr_i), .arch_new_i(arch_new_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
      .res_valid_o(res_valid_o), .res_data_o(res_data_o),
      .err_illegal_o(err_illegal_o)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirements
   function automatic logic [31:0] model(logic [1:0] op, logic [1:0] a,
                                         logic nw, logic [31:0] w);
      logic [15:0] h;
      logic [7:0]  b;
      logic [31:0] r;
      h = a[1] ? w[31:16] : w[15:0];
      b = 8'(w >> (8 * a));
      r = 32'h0;
      case (op)
         2'b01: begin
            r = {16'h0, h};
            if (!nw && a[0]) r = (r >> 8) | (r << 24);
         end
         2'b11: r = (!nw && a[0]) ? {{24{h[15]}}, h[15:8]} : {{16{h[15]}}, h};
         2'b10: r = {{24{b[7]}}, b};
         default: r = 32'h0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(logic [1:0] op, logic [1:0] a, logic nw);
      if (op == 2'b10) return "R8";
      if (op == 2'b01) return nw ? "R5 R11" : "R4 R11";
      if (!nw && a[0]) return "R6 R11";
      return "R7 R11";
   endfunction

   task automatic do_load(logic [1:0] op, logic [31:0] addr, logic nw,
                          logic [31:0] word, int lat);
      @(negedge clk);
      req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr; arch_new_i = nw;
      @(negedge clk);
      check("R2 req", {31'b0, mem_req_o}, 32'd1);
      check("R2 addr", mem_addr_o, {addr[31:2], 2'b00});
      // busy: illegal request and mode flip must be ignored (R10, R11)
      req_op_i = 2'b00; req_addr_i = ~addr; arch_new_i = ~nw;
      @(negedge clk);
      check("R2 pulse", {31'b0, mem_req_o}, 32'd0);
      check("R10 err", {31'b0, err_illegal_o}, 32'd0);
      for (int i = 1; i < lat; i++) begin
         @(negedge clk);
         check("R3 early", {31'b0, res_valid_o}, 32'd0);
         check("R10 req", {31'b0, mem_req_o}, 32'd0);
      end
      req_valid_i = 1'b0;
      mem_rvalid_i = 1'b1; mem_rdata_i = word;
      @(negedge clk);
      mem_rvalid_i = 1'b0; mem_rdata_i = $urandom;
      check("R3 valid", {31'b0, res_valid_o}, 32'd1);
      check(tag_of(op, addr[1:0], nw), res_data_o, model(op, addr[1:0], nw, word));
      check("R10 err", {31'b0, err_illegal_o}, 32'd0);
      @(negedge clk);
      check("R3 pulse", {31'b0, res_valid_o}, 32'd0);
   endtask

   task automatic do_illegal(logic [31:0] addr);
      @(negedge clk);
      req_valid_i = 1'b1; req_op_i = 2'b00; req_addr_i = addr;
      @(negedge clk);
      req_valid_i = 1'b0;
      check("R9 err", {31'b0, err_illegal_o}, 32'd1);
      check("R9 noreq", {31'b0, mem_req_o}, 32'd0);
      @(negedge clk);
      check("R9 pulse", {31'b0, err_illegal_o}, 32'd0);
      check("R9 noreq", {31'b0, mem_req_o}, 32'd0);
      check("R9 nores", {31'b0, res_valid_o}, 32'd0);
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 req", {31'b0, mem_req_o}, 32'd0);
      check("R1 res", {31'b0, res_valid_o}, 32'd0);
      check("R1 err", {31'b0, err_illegal_o}, 32'd0);
      check("R1 ready", {31'b0, req_ready_o}, 32'd1);
      rst_n = 1'b1;

      // directed odd-address corners, both modes
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 4; a++) begin
            do_load(2'b01, 32'h1000_0000 + 32'(a), m[0], 32'hA1B2_C3D4, 1);
            do_load(2'b11, 32'h2000_0000 + 32'(a), m[0], 32'h9ABC_7F80, 2);
            do_load(2'b11, 32'h2000_0010 + 32'(a), m[0], 32'h12F4_8056, 1);
            do_load(2'b10, 32'h3000_0000 + 32'(a), m[0], 32'h807F_FF01, 3);
         end
      end
      do_illegal(32'h0000_0003);
      do_illegal(32'hFFFF_FFFF);

      // random traffic
      for (int n = 0; n < 400; n++) begin
         logic [1:0] op;
         op = 2'($urandom_range(1, 3));
         if ($urandom_range(0, 19) == 0) do_illegal($urandom);
         do_load(op, $urandom, 1'($urandom), $urandom, $urandom_range(1, 4));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule